// File: doc/BRIEF.md
# Power-up reset and configuration sequencer

This block takes the chip from power-down to a ready state. While power-down is asserted, or while the oscillator is not reported stable, it waits. Once both conditions clear, it runs a fixed-length reset phase that forces every register-file entry to its hardware default. It then runs a fixed-length initialization phase that streams two 16-byte blocks of nonvolatile configuration memory into a register window. After that it settles in idle. A 6-bit command value shows progress: 3Fh throughout start-up and 00h once idle is reached. A busy flag stays high until idle.

The configuration memory lives outside the block. It is reached through a read port with one cycle of read latency. The register file is inside the block. The host reads it at any time and can write it only when the block is idle.

States and transitions: ST_WAIT goes to ST_RESET on the first clock edge where power-down is low and the oscillator is stable. ST_RESET goes to ST_INIT after RESET_CYCLES cycles. ST_INIT goes to ST_IDLE after INIT_CYCLES cycles. ST_IDLE holds. From every state, an abort (power-down high or oscillator not stable) goes to ST_WAIT on the next edge.

Top module: `startup_seq`

## Requirements
- R1: After rst_n deasserts, and for as long as pwr_down is 1 or osc_stable is 0, the block stays in ST_WAIT with busy=1, cmd_value=3Fh and cfg_rd_en=0.
- R2: The reset phase lasts RESET_CYCLES (512) cycles. During it, and on rst_n, every register entry i takes the default value A5h XOR i.
- R3: The initialization phase follows the reset phase and lasts INIT_CYCLES (128) cycles. busy is high for exactly 640 cycles after the edge that leaves ST_WAIT, then falls and stays low.
- R4: In initialization cycle k, for k = 0 to 31, cfg_rd_en=1 and cfg_addr=16+k. The byte returned on cfg_rdata one cycle later is written to register 16+k. At idle, registers 10h to 2Fh hold memory bytes 10h to 2Fh, and all other registers hold their defaults.
- R5: cmd_value is 3Fh in every state except ST_IDLE, where it is 00h. No other value ever appears.
- R6: A host write while busy is 1 has no effect on the register file.
- R7: In idle, a host write takes effect at the next clock edge. host_rdata always shows the entry selected by host_addr.
- R8: pwr_down=1 or osc_stable=0 in any state returns the block to ST_WAIT at the next edge. After that, the full 640-cycle sequence runs again.
- R9: cfg_rd_en is 0 outside the first 32 cycles of the initialization phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | Power-down request |
| osc_stable | input | 1 | Oscillator reported stable |
| busy | output | 1 | High until idle is reached |
| cmd_value | output | 6 | 3Fh during start-up, 00h at idle |
| cfg_rd_en | output | 1 | Configuration memory read strobe |
| cfg_addr | output | 6 | Configuration memory byte address |
| cfg_rdata | input | 8 | Read data, one cycle after the strobe |
| host_we | input | 1 | Host write enable |
| host_addr | input | 6 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Register contents at host_addr |

## Verification
The bench builds the block with its default values: 512 reset cycles, 128 initialization cycles, two 16-byte blocks and a 64-entry register file. At these values the bench can count the full 640-cycle busy window, copy the whole 10h to 2Fh window, and scan all 64 registers through the host port. These defaults also leave room to abort in the middle of both the reset phase and the copy, and to check that the full sequence restarts from the beginning.

// File: rtl/startup_pkg.sv
package startup_pkg;

    typedef enum logic [1:0] {
        ST_WAIT,
        ST_RESET,
        ST_INIT,
        ST_IDLE
    } seq_state_e;

    localparam logic [5:0] CMD_STARTUP = 6'h3F;
    localparam logic [5:0] CMD_IDLE    = 6'h00;

    function automatic logic [7:0] reg_default(input int idx);
        return 8'hA5 ^ 8'(idx);
    endfunction

endpackage

// File: rtl/startup_fsm.sv
module startup_fsm
    import startup_pkg::*;
#(
    parameter int RESET_CYCLES = 512,
    parameter int INIT_CYCLES  = 128,
    parameter int CW           = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort,
    output seq_state_e       state,
    output logic [CW-1:0]    cnt,
    output logic             busy,
    output logic [5:0]       cmd_value
);

    seq_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_WAIT:  nxt = ST_RESET;
            ST_RESET: if (cnt == CW'(RESET_CYCLES - 1)) nxt = ST_INIT;
            ST_INIT:  if (cnt == CW'(INIT_CYCLES - 1))  nxt = ST_IDLE;
            ST_IDLE:  nxt = ST_IDLE;
        endcase
        if (abort) nxt = ST_WAIT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_WAIT;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (nxt != state || state == ST_WAIT || state == ST_IDLE)
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        busy      = 1'b1;
        cmd_value = CMD_STARTUP;
        unique case (state)
            ST_WAIT, ST_RESET, ST_INIT: begin
                busy      = 1'b1;
                cmd_value = CMD_STARTUP;
            end
            ST_IDLE: begin
                busy      = 1'b0;
                cmd_value = CMD_IDLE;
            end
        endcase
    end

    AST_RESET_TO_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESET && cnt == CW'(RESET_CYCLES - 1) && !abort) |=> state == ST_INIT); // R2
    AST_INIT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INIT && cnt == CW'(INIT_CYCLES - 1) && !abort) |=> state == ST_IDLE); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !abort) |=> (state == ST_IDLE && !busy)); // R3
    AST_ABORT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (state == ST_WAIT && busy)); // R8

endmodule

// File: rtl/startup_copy.sv
module startup_copy #(
    parameter int COPY_LEN = 32,
    parameter int MEM_BASE = 16,
    parameter int WIN_BASE = 16,
    parameter int MEM_AW   = 6,
    parameter int REG_AW   = 6,
    parameter int CW       = 10,
    parameter int DW       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_init,
    input  logic              abort,
    input  logic [CW-1:0]     cnt,
    output logic              cfg_rd_en,
    output logic [MEM_AW-1:0] cfg_addr,
    input  logic [DW-1:0]     cfg_rdata,
    output logic              cp_we,
    output logic [REG_AW-1:0] cp_addr,
    output logic [DW-1:0]     cp_data
);

    localparam int IW = $clog2(COPY_LEN);

    logic [IW-1:0] idx;
    logic          pend_v;
    logic [IW-1:0] pend_idx;

    assign idx       = cnt[IW-1:0];
    assign cfg_rd_en = in_init && (cnt < CW'(COPY_LEN));
    assign cfg_addr  = MEM_AW'(MEM_BASE) + MEM_AW'(idx);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_v   <= 1'b0;
            pend_idx <= '0;
        end else begin
            pend_v   <= cfg_rd_en && !abort;
            pend_idx <= idx;
        end
    end

    assign cp_we   = pend_v;
    assign cp_addr = REG_AW'(WIN_BASE) + REG_AW'(pend_idx);
    assign cp_data = cfg_rdata;

    AST_RD_ONLY_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_en |-> in_init); // R9
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_en && $past(cfg_rd_en) && !$past(abort)) |-> cfg_addr == $past(cfg_addr) + 1'b1); // R4

endmodule

// File: rtl/startup_regfile.sv
module startup_regfile
    import startup_pkg::*;
#(
    parameter int REG_AW = 6,
    parameter int DW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              preset,
    input  logic              cp_we,
    input  logic [REG_AW-1:0] cp_addr,
    input  logic [DW-1:0]     cp_data,
    input  logic              host_en,
    input  logic              host_we,
    input  logic [REG_AW-1:0] host_addr,
    input  logic [DW-1:0]     host_wdata,
    output logic [DW-1:0]     host_rdata
);

    localparam int DEPTH = 1 << REG_AW;

    logic [DEPTH-1:0][DW-1:0] regs;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= DW'(reg_default(i));
        end else if (preset) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= DW'(reg_default(i));
        end else if (cp_we) begin
            regs[cp_addr] <= cp_data;
        end else if (host_en && host_we) begin
            regs[host_addr] <= host_wdata;
        end
    end

    assign host_rdata = regs[host_addr];

    AST_WE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && !host_en && !preset && !cp_we) |=> $stable(regs)); // R6

endmodule

// File: rtl/startup_seq.sv
module startup_seq
    import startup_pkg::*;
#(
    parameter int RESET_CYCLES = 512,
    parameter int INIT_CYCLES  = 128,
    parameter int BLOCK_BYTES  = 16,
    parameter int NUM_BLOCKS   = 2,
    parameter int WIN_BASE     = 16,
    parameter int REG_AW       = 6,
    parameter int MEM_AW       = 6,
    parameter int DW           = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_down,
    input  logic              osc_stable,
    output logic              busy,
    output logic [5:0]        cmd_value,
    output logic              cfg_rd_en,
    output logic [MEM_AW-1:0] cfg_addr,
    input  logic [DW-1:0]     cfg_rdata,
    input  logic              host_we,
    input  logic [REG_AW-1:0] host_addr,
    input  logic [DW-1:0]     host_wdata,
    output logic [DW-1:0]     host_rdata
);

    localparam int MAXC     = (RESET_CYCLES > INIT_CYCLES) ? RESET_CYCLES : INIT_CYCLES;
    localparam int CW       = $clog2(MAXC) + 1;
    localparam int COPY_LEN = NUM_BLOCKS * BLOCK_BYTES;
    localparam int MEM_BASE = BLOCK_BYTES;

    logic              abort;
    seq_state_e        state;
    logic [CW-1:0]     cnt;
    logic              cp_we;
    logic [REG_AW-1:0] cp_addr;
    logic [DW-1:0]     cp_data;

    assign abort = pwr_down || !osc_stable;

    startup_fsm #(
        .RESET_CYCLES(RESET_CYCLES),
        .INIT_CYCLES (INIT_CYCLES),
        .CW          (CW)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .abort    (abort),
        .state    (state),
        .cnt      (cnt),
        .busy     (busy),
        .cmd_value(cmd_value)
    );

    startup_copy #(
        .COPY_LEN(COPY_LEN),
        .MEM_BASE(MEM_BASE),
        .WIN_BASE(WIN_BASE),
        .MEM_AW  (MEM_AW),
        .REG_AW  (REG_AW),
        .CW      (CW),
        .DW      (DW)
    ) u_copy (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_init  (state == ST_INIT),
        .abort    (abort),
        .cnt      (cnt),
        .cfg_rd_en(cfg_rd_en),
        .cfg_addr (cfg_addr),
        .cfg_rdata(cfg_rdata),
        .cp_we    (cp_we),
        .cp_addr  (cp_addr),
        .cp_data  (cp_data)
    );

    startup_regfile #(
        .REG_AW(REG_AW),
        .DW    (DW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .preset    (state == ST_RESET),
        .cp_we     (cp_we),
        .cp_addr   (cp_addr),
        .cp_data   (cp_data),
        .host_en   (!busy),
        .host_we   (host_we),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .host_rdata(host_rdata)
    );

    AST_CMD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_value == CMD_IDLE) || (cmd_value == CMD_STARTUP)); // R5
    AST_CMD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> cmd_value == CMD_STARTUP); // R5
    AST_WAIT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $past(abort) |-> !cfg_rd_en); // R1

endmodule

// File: tb/test_startup_seq.sv
`timescale 1ns/100ps
module test_startup_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_down = 1'b1;
    logic       osc_stable = 1'b0;
    logic       busy;
    logic [5:0] cmd_value;
    logic       cfg_rd_en;
    logic [5:0] cfg_addr;
    logic [7:0] cfg_rdata = 8'h00;
    logic       host_we = 1'b0;
    logic [5:0] host_addr = 6'd0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    startup_seq i_startup_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_down  (pwr_down),
        .osc_stable(osc_stable),
        .busy      (busy),
        .cmd_value (cmd_value),
        .cfg_rd_en (cfg_rd_en),
        .cfg_addr  (cfg_addr),
        .cfg_rdata (cfg_rdata),
        .host_we   (host_we),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .host_rdata(host_rdata)
    );

    // configuration memory with one cycle of read latency
    logic [7:0] cfg_mem [64];
    int seed = 0;

    function automatic logic [7:0] pat(input int i, input int s);
        return 8'((i * 37 + 11) ^ (s * 8'h5C));
    endfunction

    function automatic logic [7:0] dflt(input int i);
        return 8'hA5 ^ 8'(i);
    endfunction

    task automatic load_mem(input int s);
        for (int i = 0; i < 64; i++) cfg_mem[i] = pat(i, s);
    endtask

    always @(posedge clk) if (cfg_rd_en) cfg_rdata <= cfg_mem[cfg_addr];

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // behavioural reference model: phase 0 wait, 1 reset, 2 init, 3 idle
    int         m_ph = 0;
    int         m_cnt = 0;
    logic [7:0] m_regs [64];
    bit         m_pend = 0;
    int         m_pidx = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_pend = 0;
            for (int i = 0; i < 64; i++) m_regs[i] = dflt(i);
        end else begin
            bit ab;
            ab = pwr_down || !osc_stable;
            if (m_ph == 1) begin
                for (int i = 0; i < 64; i++) m_regs[i] = dflt(i);
            end else if (m_pend) begin
                m_regs[16 + m_pidx] = cfg_mem[16 + m_pidx];
            end else if (m_ph == 3 && host_we) begin
                m_regs[host_addr] = host_wdata;
            end
            m_pend = (m_ph == 2 && m_cnt < 32 && !ab);
            m_pidx = m_cnt;
            if (ab) begin
                m_ph = 0; m_cnt = 0;
            end else if (m_ph == 0) begin
                m_ph = 1; m_cnt = 0;
            end else if (m_ph == 1) begin
                if (m_cnt == 511) begin m_ph = 2; m_cnt = 0; end else m_cnt++;
            end else if (m_ph == 2) begin
                if (m_cnt == 127) begin m_ph = 3; m_cnt = 0; end else m_cnt++;
            end
        end
    end

    always begin
        @(negedge clk);
        #1.0;
        if (rst_n) begin
            bit en;
            en = (m_ph == 2 && m_cnt < 32);
            check("R3 busy vs model", busy, m_ph != 3);
            check("R5 cmd vs model", cmd_value, (m_ph == 3) ? 6'h00 : 6'h3F);
            check("R9 cfg_rd_en vs model", cfg_rd_en, en);
            if (en) check("R4 cfg_addr vs model", cfg_addr, 16 + m_cnt);
            check("R7 host_rdata vs model", host_rdata, m_regs[host_addr]);
        end
    end

    task automatic tick();
        @(negedge clk);
        #0.5;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        for (int k = 0; k < 5000; k++) begin
            tick();
            host_addr = 6'(k);
            if (!busy) break;
            n++;
        end
    endtask

    task automatic check_window(input string req, input int s);
        for (int i = 0; i < 64; i++) begin
            host_addr = 6'(i);
            #0.2;
            check(req, host_rdata, (i >= 16 && i < 48) ? pat(i, s) : dflt(i));
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n;
        load_mem(0);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: waiting while powered down
        check("R1 busy in wait", busy, 1);
        check("R1 cmd in wait", cmd_value, 6'h3F);
        check("R1 no read in wait", cfg_rd_en, 0);
        repeat (4) tick();
        pwr_down = 1'b0;
        repeat (4) tick();
        check("R1 wait without oscillator", busy, 1);
        // R6: write while waiting has no effect
        host_we = 1'b1; host_addr = 6'd5; host_wdata = 8'h11;
        tick();
        host_we = 1'b0;
        #0.2;
        check("R6 write ignored in wait", host_rdata, dflt(5));
        // R3: full sequence length
        osc_stable = 1'b1;
        n = 0;
        for (int k = 0; k < 5000; k++) begin
            tick();
            host_addr = 6'(k);
            host_we = (k == 100 || k == 600);
            host_wdata = 8'h77;
            if (!busy) break;
            n++;
        end
        host_we = 1'b0;
        check("R3 busy length", n, 640);
        check("R5 cmd at idle", cmd_value, 6'h00);
        check_window("R4 R2 window after first start", 0);
        // R7: host writes in idle
        host_we = 1'b1; host_addr = 6'h20; host_wdata = 8'h3C;
        tick();
        host_addr = 6'h03; host_wdata = 8'hE1;
        tick();
        host_we = 1'b0;
        host_addr = 6'h20; #0.2;
        check("R7 idle write 20h", host_rdata, 8'h3C);
        host_addr = 6'h03; #0.2;
        check("R7 idle write 03h", host_rdata, 8'hE1);
        // R8: oscillator loss in idle, then abort in reset phase
        osc_stable = 1'b0;
        tick();
        check("R8 busy after loss", busy, 1);
        check("R8 cmd after loss", cmd_value, 6'h3F);
        osc_stable = 1'b1;
        for (int k = 0; k < 300; k++) tick();
        pwr_down = 1'b1;
        tick();
        check("R8 busy after abort in reset", busy, 1);
        pwr_down = 1'b0;
        wait_idle(n);
        check("R8 restart length", n, 640);
        check_window("R8 R2 window after restart", 0);
        // R8 R9: abort during the copy, with new memory contents
        seed = 1;
        load_mem(1);
        osc_stable = 1'b0;
        tick();
        osc_stable = 1'b1;
        for (int k = 0; k < 530; k++) tick();
        check("R4 reading during copy", cfg_rd_en, 1);
        osc_stable = 1'b0;
        tick();
        check("R9 no read after abort", cfg_rd_en, 0);
        osc_stable = 1'b1;
        wait_idle(n);
        check("R8 restart after copy abort", n, 640);
        check_window("R4 window with new contents", 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule